// File: doc/BRIEF.md
# Tick-Driven Timer Set with Per-Processor Timers

The block holds one system-wide timer and one timer for each processor. Every timer has an up-counter that advances on a shared tick pulse and wraps at a limit that software programs. On each wrap the timer sets a pending flag, which is presented as a level interrupt. The system timer's interrupt is meant for priority level 10. Each processor timer's interrupt is meant for level 14. Software acknowledges a pending interrupt by reading back that timer's limit word.

Software can also load a new limit without restarting the count, through a second limit word. A configuration word in the system page can turn any processor timer into a free-running counter. In that mode the timer ignores its limit, raises no interrupt, and advances only while its run bit is set.

The register bus is a plain word interface. Read data is combinational from the address, and the side effect of a read takes place at the clock edge where `bus_rd` is high.

Top module: `ctr_timer_set`

## Requirements
- R1: The address is {page, word[2:0]}. Pages 0 to NPROC-1 hold the processor timers and page NPROC holds the system timer. Word 0 is the limit, word 1 the count, word 2 the limit-without-clear, word 3 the run bit (bit 0, processor pages only) and word 4 the configuration (system page only, bit i = mode of processor timer i). Words 0 and 2 both read back the limit, and any unused location reads 0.
- R2: After reset every count, limit, run bit and configuration bit is 0, all timers are in timer mode, and no interrupt is pending.
- R3: In timer mode with a nonzero limit, a tick advances the count by 1. A tick that finds the count at or above the limit instead sets the count to 1 and sets the pending interrupt, which appears the cycle after that tick.
- R4: A pending interrupt stays high until the timer's limit word (word 0) is read. The read clears it at that edge, unless a wrap occurs in the same cycle.
- R5: A write to word 0 loads the limit, sets the count to 1 and clears the pending interrupt. It takes precedence over a tick in the same cycle.
- R6: A write to word 2 loads the limit and leaves both the count and the pending interrupt untouched.
- R7: A timer in timer mode whose limit is 0 is idle: ticks leave its count unchanged and it never interrupts.
- R8: With configuration bit i at 1, processor timer i counts ticks only while its run bit is 1. It ignores the limit, wraps from all ones to 0, and holds no pending interrupt. Writing 0 to the configuration word returns every processor timer to timer mode.
- R9: In timer mode the run bit has no effect on counting.
- R10: The system timer's pending flag drives `irq_sys` and processor timer i drives `irq_cpu[i]`. Writes to the count word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count pulse shared by all timers |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (acknowledge side effect) |
| bus_addr | input | AW | Word address {page, word} |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for the current address |
| irq_sys | output | 1 | System timer interrupt (level 10) |
| irq_cpu | output | NPROC | Per-processor timer interrupts (level 14) |

## Verification
The properties assume that `bus_rd` and `bus_wr` are not high in the same cycle, and that `tick` is a single-cycle strobe sampled like any other input. The acknowledge and hold properties also rely on the system page being addressed by the exact encoding {NPROC, 0}. The stimulus drives at most one bus operation per cycle and draws every address from the defined pages plus one page past the end. Limits are kept small, so wraps, acknowledges racing with wraps, and idle zero limits all occur often.

// File: rtl/ctr_timer_set.sv
module ctr_timer_set #(
  parameter int NPROC = 2,
  parameter int CW = 16,
  localparam int NT = NPROC + 1,
  localparam int PW = $clog2(NT + 1),
  localparam int AW = PW + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CW-1:0]    bus_wdata,
  output logic [CW-1:0]    bus_rdata,
  output logic             irq_sys,
  output logic [NPROC-1:0] irq_cpu
);
  logic [PW-1:0]    page;
  logic [2:0]       word;
  logic [CW-1:0]    lim_v [NT];
  logic [CW-1:0]    cnt_v [NT];
  logic [NT-1:0]    irq_v;
  logic [NT-1:0]    fr;
  logic [NT-1:0]    adv;
  logic [NPROC-1:0] run_v;
  logic [NPROC-1:0] cfg_mode;

  assign page = bus_addr[AW-1:3];
  assign word = bus_addr[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_mode <= '0;
    else if (bus_wr && page == PW'(NPROC) && word == 3'd4) cfg_mode <= bus_wdata[NPROC-1:0];
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic [CW-1:0] lim_r, cnt_r;
    logic          irq_r;
    logic          sel, wr_lim, wr_lnc, rd_lim, active, wrap;

    assign sel    = page == PW'(t);
    assign wr_lim = bus_wr & sel & (word == 3'd0);
    assign wr_lnc = bus_wr & sel & (word == 3'd2);
    assign rd_lim = bus_rd & sel & (word == 3'd0);
    assign active = tick & (lim_r != '0);
    assign wrap   = active & (cnt_r >= lim_r);

    if (t < NPROC) begin : g_cpu
      logic run_r;
      always_ff @(posedge clk) begin
        if (!rst_n) run_r <= 1'b0;
        else if (bus_wr && sel && word == 3'd3) run_r <= bus_wdata[0];
      end
      assign run_v[t] = run_r;
      assign fr[t]    = cfg_mode[t];
      assign adv[t]   = tick & run_r;
    end else begin : g_sys
      assign fr[t]  = 1'b0;
      assign adv[t] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lim_r <= '0;
        cnt_r <= '0;
        irq_r <= 1'b0;
      end else if (wr_lim) begin
        lim_r <= bus_wdata;
        cnt_r <= CW'(1);
        irq_r <= 1'b0;
      end else begin
        if (wr_lnc) lim_r <= bus_wdata;
        if (fr[t]) begin
          irq_r <= 1'b0;
          if (adv[t]) cnt_r <= cnt_r + CW'(1);
        end else if (wrap) begin
          cnt_r <= CW'(1);
          irq_r <= 1'b1;
        end else begin
          if (active) cnt_r <= cnt_r + CW'(1);
          if (rd_lim) irq_r <= 1'b0;
        end
      end
    end

    assign lim_v[t] = lim_r;
    assign cnt_v[t] = cnt_r;
    assign irq_v[t] = irq_r;
  end

  always_comb begin
    bus_rdata = '0;
    for (int t = 0; t < NT; t++) begin
      if (page == PW'(t)) begin
        case (word)
          3'd0, 3'd2: bus_rdata = lim_v[t];
          3'd1:       bus_rdata = cnt_v[t];
          3'd3:       if (t < NPROC) bus_rdata = CW'(run_v[t % NPROC]);
          3'd4:       if (t == NPROC) bus_rdata = CW'(cfg_mode);
          default:    bus_rdata = '0;
        endcase
      end
    end
  end

  assign irq_sys = irq_v[NPROC];
  assign irq_cpu = irq_v[NPROC-1:0];
endmodule

module ctr_timer_set_chk #(
  parameter int NPROC = 2,
  parameter int AW = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [AW-1:0]    bus_addr,
  input logic             irq_sys,
  input logic [NPROC-1:0] irq_cpu,
  input logic [NPROC-1:0] cfg_mode
);
  logic [AW-1:0] sys_lim;
  assign sys_lim = {(AW-3)'(NPROC), 3'b000};

  // R3
  sys_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sys) |-> $past(tick));

  // R3
  cpu_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_cpu[0]) |-> $past(tick));

  // R5
  limit_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == sys_lim) |=> !irq_sys);

  // R4
  limit_read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !tick && bus_addr == sys_lim) |=> !irq_sys);

  // R4
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sys && !tick && !bus_rd && !bus_wr) |=> irq_sys);

  // R8
  free_run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[0] && $past(cfg_mode[0])) |-> !irq_cpu[0]);
endmodule

bind ctr_timer_set ctr_timer_set_chk #(.NPROC(NPROC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .irq_sys(irq_sys), .irq_cpu(irq_cpu), .cfg_mode(cfg_mode)
);

// File: tb/ctr_timer_set_tb.sv
module ctr_timer_set_tb;
  localparam int NP = 2;
  localparam int CW = 16;
  localparam int NT = NP + 1;
  localparam int PW = $clog2(NT + 1);
  localparam int AW = PW + 3;

  logic clk = 0, rst_n = 0, tick = 0, bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0, bus_rdata;
  logic irq_sys;
  logic [NP-1:0] irq_cpu;

  int total = 0, bad = 0;

  logic [CW-1:0] m_lim [NT];
  logic [CW-1:0] m_cnt [NT];
  logic [NT-1:0] m_irq;
  logic [NP-1:0] m_run, m_mode;

  ctr_timer_set #(.NPROC(NP), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sys(irq_sys), .irq_cpu(irq_cpu)
  );

  always #5 clk = ~clk;

  function automatic logic [AW-1:0] adr(int pg, int wd);
    return {PW'(pg), 3'(wd)};
  endfunction

  task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] exp_rd();
    int pg = int'(bus_addr[AW-1:3]);
    int wd = int'(bus_addr[2:0]);
    if (pg >= NT) return '0;
    case (wd)
      0, 2: return m_lim[pg];
      1: return m_cnt[pg];
      3: return (pg < NP) ? CW'(m_run[pg % NP]) : '0;
      4: return (pg == NP) ? CW'(m_mode) : '0;
      default: return '0;
    endcase
  endfunction

  task automatic model_step();
    int pg = int'(bus_addr[AW-1:3]);
    int wd = int'(bus_addr[2:0]);
    logic [NP-1:0] nrun = m_run;
    logic [NP-1:0] nmode = m_mode;
    for (int t = 0; t < NT; t++) begin
      logic [CW-1:0] nl = m_lim[t], nc = m_cnt[t];
      logic ni = m_irq[t];
      logic free = (t < NP) && m_mode[t % NP];
      logic act = tick && m_lim[t] != 0;
      if (bus_wr && pg == t && wd == 0) begin
        nl = bus_wdata; nc = 1; ni = 0;
      end else begin
        if (bus_wr && pg == t && wd == 2) nl = bus_wdata;
        if (free) begin
          ni = 0;
          if (tick && m_run[t % NP]) nc = m_cnt[t] + 1;
        end else if (act && m_cnt[t] >= m_lim[t]) begin
          nc = 1; ni = 1;
        end else begin
          if (act) nc = m_cnt[t] + 1;
          if (bus_rd && pg == t && wd == 0) ni = 0;
        end
      end
      m_lim[t] = nl; m_cnt[t] = nc; m_irq[t] = ni;
    end
    if (bus_wr && pg < NP && wd == 3) nrun[pg % NP] = bus_wdata[0];
    if (bus_wr && pg == NP && wd == 4) nmode = bus_wdata[NP-1:0];
    m_run = nrun; m_mode = nmode;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tick = 0;
    chk("R10 irq_sys", CW'(irq_sys), CW'(m_irq[NP]));
    chk("R10 irq_cpu", CW'(irq_cpu), CW'(m_irq[NP-1:0]));
  endtask

  task automatic op_idle(logic tk);
    tick = tk; cyc();
  endtask

  task automatic op_wr(int pg, int wd, logic [CW-1:0] d, logic tk);
    bus_addr = adr(pg, wd); bus_wdata = d; bus_wr = 1; tick = tk; cyc();
  endtask

  task automatic op_rd(int pg, int wd, logic tk, output logic [CW-1:0] v);
    string tag;
    bus_addr = adr(pg, wd); bus_rd = 1; tick = tk;
    #1;
    v = bus_rdata;
    case (wd)
      0: tag = "R1 limit read";
      1: tag = "R3 count read";
      2: tag = "R6 limit-nc read";
      3: tag = "R9 run read";
      default: tag = "R8 config read";
    endcase
    chk(tag, bus_rdata, exp_rd());
    cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] v;
    for (int t = 0; t < NT; t++) begin m_lim[t] = 0; m_cnt[t] = 0; end
    m_irq = 0; m_run = 0; m_mode = 0;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R2 irq_sys after reset", CW'(irq_sys), 0);
    chk("R2 irq_cpu after reset", CW'(irq_cpu), 0);
    op_rd(NP, 4, 0, v); chk("R2 config after reset", v, 0);
    op_rd(NP, 1, 1, v); chk("R2 count after reset", v, 0);

    op_wr(NP, 0, 3, 1);
    op_rd(NP, 1, 0, v); chk("R5 count after limit write", v, 1);
    for (int i = 0; i < 3; i++) op_idle(1);
    chk("R3 wrap interrupt", CW'(irq_sys), 1);
    op_rd(NP, 1, 0, v); chk("R3 count after wrap", v, 1);

    op_wr(NP, 2, 5, 0);
    chk("R6 pending kept", CW'(irq_sys), 1);
    op_rd(NP, 1, 0, v); chk("R6 count kept", v, 1);
    for (int i = 0; i < 3; i++) op_idle(0);
    chk("R4 pending held", CW'(irq_sys), 1);
    op_rd(NP, 0, 0, v);
    chk("R4 acknowledged by limit read", CW'(irq_sys), 0);

    op_wr(0, 0, 0, 0);
    for (int i = 0; i < 10; i++) op_idle(1);
    op_rd(0, 1, 0, v); chk("R7 idle count", v, 1);
    chk("R7 no interrupt", CW'(irq_cpu[0]), 0);

    op_wr(NP, 4, 1, 0);
    op_wr(0, 3, 1, 0);
    for (int i = 0; i < 4; i++) op_idle(1);
    op_rd(0, 1, 0, v); chk("R8 free-run count", v, 5);
    op_wr(0, 1, 16'h0077, 1);
    op_rd(0, 1, 0, v); chk("R10 count write ignored", v, 6);

    op_wr(NP, 4, 0, 0);
    op_wr(1, 3, 0, 0);
    op_wr(1, 0, 2, 0);
    op_idle(1); op_idle(1);
    chk("R9 timer counts with run bit clear", CW'(irq_cpu[1]), 1);

    for (int i = 0; i < 5000; i++) begin
      int r = $urandom % 16;
      logic tk = 1'($urandom % 2);
      int pg = $urandom % (NT + 1);
      int wd = $urandom % 5;
      case (r)
        0, 1, 2: op_rd(pg, wd, tk, v);
        3: op_wr(pg, 0, CW'($urandom % 6), tk);
        4: op_wr(pg, 2, CW'($urandom % 6), tk);
        5: op_wr(pg, 3, CW'($urandom % 2), tk);
        6: op_wr(NP, 4, CW'($urandom % 4), tk);
        7: op_wr(pg, 1, CW'($urandom), tk);
        8: op_rd(pg, 0, tk, v);
        default: op_idle(tk);
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule